// File: doc/BRIEF.md
# ISDN B-Channel Time-Slot Port

This block moves one 8-bit voice sample per frame between a parallel byte interface and a 2B+D serial line. Each frame it sends one byte and receives one byte. It works in one of two timing formats, selected by an input. In the two-clocks-per-bit format (GCI), each bit cell is two data-clock periods long and data changes on rising edges. In the one-clock-per-bit format (IDL), a one-clock sync pulse is followed by two byte slots: one starts on rising edge 1, the other on rising edge 11. A second input chooses the first or second B slot. That choice applies to both directions.

A single system clock runs the whole block. The data clock, frame sync and serial receive line are treated as sampled inputs. They pass through a synchronizer, and the block works on the rising and falling transitions it detects in the sampled data clock. The serial transmit output is modelled as a data bit plus an output enable. The enable is high only while the selected slot is on the line, so other devices can share the wire.

Top module: `bslot_port`

## Requirements
- R1: `b2_sel` low selects the first B slot and high selects the second, for transmit and receive alike.
- R2: With `fmt_idl` low (GCI), rising data-clock edges are numbered from 0 at the frame sync edge. Bit b of the selected slot is driven from rising edge S+2b for two clock periods, with S = 0 for the first slot and S = 16 for the second.
- R3: In GCI, `txd_en` falls at the falling data-clock edge that ends the sixteenth clock of the slot, i.e. after rising edge S+15.
- R4: In GCI, each received bit is sampled on the second rising edge of its two-clock cell (rising edge S+2b+1).
- R5: With `fmt_idl` high (IDL), bit b is driven from rising edge S+b after sync, with S = 1 or 11. `txd_en` falls on falling edge S+7 (8 or 18).
- R6: In IDL, bit b is sampled on the falling edge that follows rising edge S+b (falling edges 1..8 or 11..18).
- R7: Bytes are sent and received MSB first: bit b of the slot carries byte bit 7-b.
- R8: `txd_en` is low during reset, outside the selected slot, during the other channel's slot, and until the first frame sync.
- R9: `rx_valid` pulses high for exactly one system cycle per frame, after the slot's last receive sample, together with the assembled byte on `rx_byte`.
- R10: `tx_byte` is captured at the first bit edge of the slot. Changes to it later in that slot do not change what is sent.
- R11: A frame sync is taken at a rising data-clock edge (GCI) or a falling edge (IDL) that sees `fsync` high when the previous such edge, or reset, saw it low. A sync held high over several edges starts only one frame, and with no sync nothing is driven or received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_idl | input | 1 | Timing format: 0 = GCI (two clocks per bit), 1 = IDL |
| b2_sel | input | 1 | Slot select: 0 = first B slot, 1 = second B slot |
| dclk | input | 1 | Serial data clock, asynchronous to `clk` |
| fsync | input | 1 | Frame sync |
| rxd | input | 1 | Serial receive data |
| tx_byte | input | DATA_W | Byte to send in the next selected slot |
| txd | output | 1 | Serial transmit data |
| txd_en | output | 1 | Transmit output enable; low means high impedance |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |

## Verification
The bench uses the default parameters: an 8-bit sample, two synchronizer stages, a 6-bit edge counter, and the second IDL slot at edge 11. Each data-clock half period is eight system cycles, so the synchronizer and output register settle well before each check point. Each 40-clock frame stays below the counter limit. After reset the counter sits saturated, so the no-sync case is covered. Both formats and both slots are driven with distinct bytes. Receive bits outside the slot are toggled on every clock, so a sample taken on the wrong edge shows up as a wrong byte.

// File: rtl/bslot_pkg.sv
package bslot_pkg;

    // Serial timing format selected at the fmt_idl port
    typedef enum logic {
        FMT_GCI = 1'b0,
        FMT_IDL = 1'b1
    } fmt_e;

endpackage

// File: rtl/bslot_sync.sv
module bslot_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bslot_timing.sv
module bslot_timing
    import bslot_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic             dclk_s,
    input  logic             fs_s,
    output logic             rise_evt,
    output logic             fall_evt,
    output logic [CNT_W-1:0] pos
);

    localparam logic [CNT_W-1:0] CNT_IDLE = '1;

    typedef struct packed {
        logic             dclk;
        logic             fs_last;
        logic [CNT_W-1:0] cnt;
    } tim_t;

    tim_t tim_d, tim_q;
    logic fmt_edge;
    logic sync_evt;

    always_comb begin
        tim_d    = tim_q;
        rise_evt = dclk_s & ~tim_q.dclk;
        fall_evt = ~dclk_s & tim_q.dclk;
        fmt_edge = (fmt == FMT_GCI) ? rise_evt : fall_evt;
        sync_evt = fmt_edge & fs_s & ~tim_q.fs_last;

        tim_d.dclk = dclk_s;
        if (fmt_edge) tim_d.fs_last = fs_s;

        // rising edges are numbered from the sync edge; saturate when idle
        if (sync_evt)
            tim_d.cnt = '0;
        else if (rise_evt && tim_q.cnt != CNT_IDLE)
            tim_d.cnt = tim_q.cnt + 1'b1;

        pos = tim_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q.dclk    <= 1'b0;
            tim_q.fs_last <= 1'b0;
            tim_q.cnt     <= CNT_IDLE;
        end else begin
            tim_q <= tim_d;
        end
    end

endmodule

// File: rtl/bslot_lane.sv
module bslot_lane
    import bslot_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 6,
    parameter int IDL_B1_AT = 1,
    parameter int IDL_B2_AT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              b2_sel,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic [CNT_W-1:0]  pos,
    input  logic              rxd_s,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              txd,
    output logic              txd_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int GCI_SPAN = DATA_W * 2;
    localparam int IDL_SPAN = DATA_W;

    typedef struct packed {
        logic [DATA_W-2:0] tx_sh;
        logic              txd;
        logic              txd_en;
        logic [DATA_W-2:0] rx_sh;
        logic [DATA_W-1:0] rx_byte;
        logic              rx_valid;
    } lane_t;

    lane_t lane_d, lane_q;

    logic [CNT_W-1:0]  start;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  off;
    logic              in_win;
    logic              last;
    logic              bit_edge;
    logic              cap_half;
    logic              cap_evt;
    logic [DATA_W-1:0] rx_full;

    always_comb begin
        if (fmt == FMT_GCI) begin
            start    = b2_sel ? CNT_W'(GCI_SPAN) : '0;
            span     = CNT_W'(GCI_SPAN);
        end else begin
            start    = b2_sel ? CNT_W'(IDL_B2_AT) : CNT_W'(IDL_B1_AT);
            span     = CNT_W'(IDL_SPAN);
        end
        off      = pos - start;
        in_win   = (pos >= start) && (off < span);
        last     = (off == span - 1'b1);
        bit_edge = (fmt == FMT_GCI) ? ~off[0] : 1'b1;
        cap_half = (fmt == FMT_GCI) ?  off[0] : 1'b1;
        cap_evt  = (fmt == FMT_GCI) ? rise_evt : fall_evt;
        rx_full  = {lane_q.rx_sh, rxd_s};

        lane_d          = lane_q;
        lane_d.rx_valid = 1'b0;

        // transmit: bits change on rising edges inside the window
        if (rise_evt) begin
            if (in_win) begin
                lane_d.txd_en = 1'b1;
                if (off == '0) begin
                    lane_d.txd   = tx_byte[DATA_W-1];
                    lane_d.tx_sh = tx_byte[DATA_W-2:0];
                end else if (bit_edge) begin
                    lane_d.txd   = lane_q.tx_sh[DATA_W-2];
                    lane_d.tx_sh = {lane_q.tx_sh[DATA_W-3:0], 1'b0};
                end
            end else begin
                lane_d.txd_en = 1'b0;
            end
        end
        if (fall_evt && in_win && last)
            lane_d.txd_en = 1'b0;

        // receive: one sample per cell on the format's capture edge
        if (cap_evt && in_win && cap_half) begin
            lane_d.rx_sh = rx_full[DATA_W-2:0];
            if (last) begin
                lane_d.rx_byte  = rx_full;
                lane_d.rx_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign txd      = lane_q.txd;
    assign txd_en   = lane_q.txd_en;
    assign rx_byte  = lane_q.rx_byte;
    assign rx_valid = lane_q.rx_valid;

endmodule

// File: rtl/bslot_port.sv
module bslot_port
    import bslot_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6,
    parameter int IDL_B1_AT   = 1,
    parameter int IDL_B2_AT   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_idl,
    input  logic              b2_sel,
    input  logic              dclk,
    input  logic              fsync,
    input  logic              rxd,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              txd,
    output logic              txd_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int LINE_W = 3;

    logic [LINE_W-1:0] line_s;
    logic              rise_evt;
    logic              fall_evt;
    logic [CNT_W-1:0]  pos;
    fmt_e              fmt;

    assign fmt = fmt_e'(fmt_idl);

    bslot_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dclk, fsync, rxd}),
        .sync_o  (line_s)
    );

    bslot_timing #(
        .CNT_W (CNT_W)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (fmt),
        .dclk_s   (line_s[2]),
        .fs_s     (line_s[1]),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .pos      (pos)
    );

    bslot_lane #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .IDL_B1_AT (IDL_B1_AT),
        .IDL_B2_AT (IDL_B2_AT)
    ) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (fmt),
        .b2_sel   (b2_sel),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .pos      (pos),
        .rxd_s    (line_s[0]),
        .tx_byte  (tx_byte),
        .txd      (txd),
        .txd_en   (txd_en),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/bslot_port_chk.sv
module bslot_port_chk (
    input logic clk,
    input logic rst_n,
    input logic fmt_idl,
    input logic rise_evt,
    input logic fall_evt,
    input logic txd,
    input logic txd_en,
    input logic rx_valid
);

    // driving only begins on a detected rising data-clock edge
    assert_drive_starts_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txd_en) |-> $past(rise_evt));

    // the line is released only on a detected falling data-clock edge
    assert_release_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd_en) |-> $past(fall_evt));

    // while driving, the data bit moves only after a rising edge
    assert_txd_moves_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_en && $past(txd_en) && !$past(rise_evt)) |-> $stable(txd));

    // the byte strobe lasts one cycle
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // GCI completes reception on a rising edge
    assert_gci_rx_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(fmt_idl)) |-> $past(rise_evt));

    // IDL completes reception on a falling edge
    assert_idl_rx_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(fmt_idl)) |-> $past(fall_evt));

endmodule

bind bslot_port bslot_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_idl  (fmt_idl),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .txd      (txd),
    .txd_en   (txd_en),
    .rx_valid (rx_valid)
);

// File: tb/bslot_port_test.sv
`timescale 1ns/1ps
module bslot_port_test;

    localparam int FRAME_CLKS = 40;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_idl = 1'b0;
    logic       b2_sel = 1'b0;
    logic       dclk = 1'b0;
    logic       fsync = 1'b0;
    logic       rxd = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       txd;
    logic       txd_en;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int tests = 0;
    int fails = 0;
    int cur_k = -1;
    bit cur_ph = 1'b0;
    int vcount = 0;
    int vk = -1;
    bit vph = 1'b0;
    logic [7:0] vdata = 8'h00;

    always #2 clk = ~clk;

    bslot_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_idl  (fmt_idl),
        .b2_sel   (b2_sel),
        .dclk     (dclk),
        .fsync    (fsync),
        .rxd      (rxd),
        .tx_byte  (tx_byte),
        .txd      (txd),
        .txd_en   (txd_en),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount = vcount + 1;
            vk     = cur_k;
            vph    = cur_ph;
            vdata  = rx_byte;
        end
    end

    task automatic chk(bit ok, string req, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    // one frame; rising edge k carries index k (0 = sync edge in GCI)
    task automatic run_frame(bit idl, bit b2, logic [7:0] txb, logic [7:0] rxb,
                             int fs_len, int chg_k, logic [7:0] chg_val, string tag);
        int s = idl ? (b2 ? 11 : 1) : (b2 ? 16 : 0);
        int w = idl ? 1 : 2;
        int l = 8 * w;
        fmt_idl = idl;
        b2_sel  = b2;
        tx_byte = txb;
        vcount  = 0;
        for (int k = 0; k < FRAME_CLKS; k++) begin
            int  off = k - s;
            bit  inw = (k >= s) && (off < l);
            bit  exp_en;
            @(negedge clk);
            dclk   = 1'b1;
            fsync  = (k < fs_len);
            rxd    = inw ? rxb[7 - off / w] : k[0];
            if (k == chg_k) tx_byte = chg_val;
            cur_k  = k;
            cur_ph = 1'b1;
            repeat (HALF - 1) @(negedge clk);
            chk(txd_en == inw, inw ? (idl ? "R5" : "R2") : "R8", tag, txd_en, inw);
            if (inw)
                chk(txd == txb[7 - off / w], "R7", tag, txd, txb[7 - off / w]);
            @(negedge clk);
            dclk   = 1'b0;
            cur_ph = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            exp_en = inw && (off != l - 1);
            chk(txd_en == exp_en, inw ? (idl ? "R5" : "R3") : "R8", tag, txd_en, exp_en);
        end
        chk(vcount == 1, "R9", tag, vcount, 1);
        chk(vdata == rxb, idl ? "R6" : "R4", tag, vdata, rxb);
        chk(vk == s + l - 1, "R9", tag, vk, s + l - 1);
        chk(vph == !idl, "R9", tag, vph, !idl);
    endtask

    task automatic t_reset();
        chk(txd_en == 1'b0, "R8", "reset", txd_en, 0);
        chk(rx_valid == 1'b0, "R9", "reset", rx_valid, 0);
    endtask

    task automatic t_no_sync();
        vcount  = 0;
        fmt_idl = 1'b0;
        tx_byte = 8'hFF;
        for (int k = 0; k < FRAME_CLKS; k++) begin
            @(negedge clk);
            dclk  = 1'b1;
            fsync = 1'b0;
            rxd   = k[0];
            repeat (HALF - 1) @(negedge clk);
            chk(txd_en == 1'b0, "R11", "no sync", txd_en, 0);
            @(negedge clk);
            dclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            chk(txd_en == 1'b0, "R8", "no sync", txd_en, 0);
        end
        chk(vcount == 0, "R11", "no sync", vcount, 0);
    endtask

    task automatic t_gci_b1();
        run_frame(1'b0, 1'b0, 8'hA5, 8'h3C, 1, -1, 8'h00, "R1 gci b1");
    endtask

    task automatic t_gci_b2();
        run_frame(1'b0, 1'b1, 8'h81, 8'h7E, 1, -1, 8'h00, "R1 gci b2");
    endtask

    task automatic t_idl_b1();
        run_frame(1'b1, 1'b0, 8'hC3, 8'h96, 1, -1, 8'h00, "R1 idl b1");
    endtask

    task automatic t_idl_b2();
        run_frame(1'b1, 1'b1, 8'h5A, 8'hE1, 1, -1, 8'h00, "R1 idl b2");
    endtask

    task automatic t_extremes();
        run_frame(1'b1, 1'b0, 8'hFF, 8'h00, 1, -1, 8'h00, "idl all ones");
        run_frame(1'b0, 1'b1, 8'h00, 8'hFF, 1, -1, 8'h00, "gci all zeros");
    endtask

    task automatic t_tx_latch();
        // R10: tx_byte altered in the middle of the slot
        run_frame(1'b0, 1'b0, 8'h69, 8'h12, 1, 5, 8'h96, "R10 gci latch");
        run_frame(1'b1, 1'b1, 8'h0F, 8'hF0, 1, 13, 8'hF0, "R10 idl latch");
    endtask

    task automatic t_long_sync();
        // R11: sync high over three edges starts a single frame
        run_frame(1'b0, 1'b0, 8'hB4, 8'h4B, 3, -1, 8'h00, "R11 long sync");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_no_sync();
        t_gci_b1();
        t_gci_b2();
        t_idl_b1();
        t_idl_b2();
        t_extremes();
        t_tx_latch();
        t_long_sync();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule